// File: doc/BRIEF.md
# Timed Peripheral Read Sequencer

This block performs single read accesses on a slow byte-wide peripheral bus whose timing is measured in hundreds of nanoseconds. A host presents an 11-bit word address and a one-cycle start request. The sequencer then steps through three fixed-length phases. First it drives the address with both strobes inactive. Next it pulls the active-low read strobe and chip-enable low together and holds them until the minimum width has passed and the peripheral acknowledges. Finally it releases both strobes while keeping the address steady, and it samples the byte midway through that last phase. The minimum low time of a strobe, the length of each step and the minimum high time of chip-enable between accesses are all given in nanoseconds. They are turned into clock counts by rounding up, so a faster clock lengthens no interval below its minimum.

The data is sampled after the strobes have returned high, not while they are low. This matches a peripheral that keeps its data valid for a short time after the strobe rises. The captured byte stays in a register after the access ends, and a one-cycle done pulse marks the load. Busy covers the whole access and also the recovery time that follows. A start request that arrives while busy is high is discarded, not queued.

Top module: `periph_read_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows rd_n_o=1, ce_n_o=1, busy_o=0, done_o=0 and data_o=0.
- R2: A start_i sampled high while busy_o is low raises busy_o on that edge and puts addr_i on bus_a_o. Both strobes then stay high for the first step of STEP_CYC = ceil(STEP_NS/CLK_NS) cycles (2 at the defaults).
- R3: rd_n_o and ce_n_o always change together. They fall on the edge that ends the first step and stay low for at least max(STEP_CYC, ceil(STROBE_NS/CLK_NS)) cycles (2 at the defaults).
- R4: After that minimum, the strobes rise on the first clock edge at which ack_i is sampled high. While ack_i stays low, they stay low.
- R5: bus_a_o does not change while busy_o stays high, so the address is held up to and past the rising strobe edge.
- R6: data_o loads bus_d_i at the edge that comes ceil(STEP_NS/(2*CLK_NS)) cycles after the strobes rise (1 at the defaults). done_o is high for exactly the one cycle after that load.
- R7: data_o keeps the captured byte, whatever bus_d_i does, until the next capture or reset.
- R8: The step after the strobes rise lasts STEP_CYC cycles. busy_o then stays high until ceil(RECOVER_NS/CLK_NS) cycles (3 at the defaults) have passed since chip-enable rose. So chip-enable is high for at least that long between accesses.
- R9: A start_i sampled while busy_o is high has no effect: no second access follows, and bus_a_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request one read access |
| addr_i | input | 11 | Word address of the access, sampled with start_i |
| busy_o | output | 1 | Access or recovery in progress |
| done_o | output | 1 | One-cycle pulse when data_o is loaded |
| data_o | output | 8 | Last byte captured |
| ack_i | input | 1 | Peripheral acknowledge, allows the strobe to end |
| bus_a_o | output | 11 | Address lines to the peripheral |
| rd_n_o | output | 1 | Read strobe, active low |
| ce_n_o | output | 1 | Chip-enable, active low |
| bus_d_i | input | 8 | Peripheral data lines |

## Verification
Cycles are counted from the edge that samples start_i, which is edge 0. With the defaults, the strobes are low from edge 2 up to edge j. Here j is 4, or one edge after the cycle in which the bench raises ack_i, whichever is later. done_o and the new data_o appear after edge j+1, and busy_o drops after edge j+3. Each access task computes j from the acknowledge delay it applies. In every cycle it samples all outputs at the falling clock edge against the value predicted for that cycle index. It drives bus_d_i with the expected byte only up to the cycle of the rising strobe and with its complement afterwards, so a capture on the wrong edge shows up as a wrong byte.

// File: rtl/rdseq_pkg.sv
// Shared types and helpers for the timed peripheral read sequencer.
// Assumes all time parameters are positive integers in nanoseconds.
package rdseq_pkg;

    // Access phases, in the order one read walks through them.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ADDR    = 3'd1,
        ST_STROBE  = 3'd2,
        ST_RELEASE = 3'd3,
        ST_RECOVER = 3'd4
    } rdseq_state_e;

    // Integer division rounded up, used to turn ns minimums into clock counts.
    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    // Larger of two counts.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rdseq_phase_timer.sv
// Phase timer: counts clock cycles spent in the current phase.
// Cleared by the controller on every phase change; saturates at CNT_MAX so
// that a long acknowledge stall never wraps the count.
module rdseq_phase_timer #(
    parameter int unsigned CNT_W   = 2,
    parameter int unsigned CNT_MAX = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] SAT = CNT_W'(CNT_MAX);

    // Count cycles within a phase, restart on clear, hold at saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (cnt_o != SAT) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/rdseq_ctrl.sv
// Phase controller: walks address setup, strobe, release and recovery.
// Drives the strobes and busy from registers loaded with the next phase so
// that the pins change exactly on the edge that enters a phase.
// Assumes STEP_CYC >= 1, LOW_CYC >= STEP_CYC and 1 <= CAPT_CYC <= STEP_CYC.
module rdseq_ctrl
    import rdseq_pkg::*;
#(
    parameter int unsigned CNT_W     = 2,
    parameter int unsigned STEP_CYC  = 2,
    parameter int unsigned LOW_CYC   = 2,
    parameter int unsigned REC_EXTRA = 1,
    parameter int unsigned CAPT_CYC  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ack_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             phase_clr_o,
    output logic             load_addr_o,
    output logic             capture_o,
    output logic             busy_o,
    output logic             rd_n_o,
    output logic             ce_n_o
);

    localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(STEP_CYC - 1);
    localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(LOW_CYC - 1);
    localparam logic [CNT_W-1:0] CAPT_LAST = CNT_W'(CAPT_CYC - 1);

    rdseq_state_e state_q;
    rdseq_state_e state_d;
    rdseq_state_e rel_exit;
    logic         rec_done;

    // Choose where the release step goes: an extra recovery phase only when
    // the release step alone is shorter than the chip-enable recovery time.
    generate
        if (REC_EXTRA > 0) begin : g_rec
            localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_EXTRA - 1);
            assign rel_exit = ST_RECOVER;
            assign rec_done = (cnt_i == REC_LAST);
        end else begin : g_norec
            assign rel_exit = ST_IDLE;
            assign rec_done = 1'b1;
        end
    endgenerate

    // Next-phase decision from the current phase, the timer and the inputs.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i)                         state_d = ST_ADDR;
            ST_ADDR:    if (cnt_i == STEP_LAST)              state_d = ST_STROBE;
            ST_STROBE:  if ((cnt_i >= LOW_LAST) && ack_i)    state_d = ST_RELEASE;
            ST_RELEASE: if (cnt_i == STEP_LAST)              state_d = rel_exit;
            ST_RECOVER: if (rec_done)                        state_d = ST_IDLE;
            default:                                         state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Pin registers, loaded from the next phase so they switch on phase entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_n_o <= 1'b1;
            ce_n_o <= 1'b1;
            busy_o <= 1'b0;
        end else begin
            rd_n_o <= (state_d != ST_STROBE);
            ce_n_o <= (state_d != ST_STROBE);
            busy_o <= (state_d != ST_IDLE);
        end
    end

    // Timer restart on every phase change.
    assign phase_clr_o = (state_d != state_q);

    // Address latch enable: an accepted start in the idle phase only.
    assign load_addr_o = (state_q == ST_IDLE) && start_i;

    // Capture point inside the release step.
    assign capture_o = (state_q == ST_RELEASE) && (cnt_i == CAPT_LAST);

endmodule

// File: rtl/rdseq_addr_hold.sv
// Address holder: latches the host address when an access is accepted and
// keeps it on the bus lines until the next accepted access.
module rdseq_addr_hold #(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] bus_a_o
);

    // Hold the address of the access in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_a_o <= '0;
        end else if (load_i) begin
            bus_a_o <= addr_i;
        end
    end

endmodule

// File: rtl/rdseq_capture.sv
// Data capture: stores the bus byte at the capture point and flags the load
// with a one-cycle done pulse. The byte is kept until the next capture.
module rdseq_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] bus_d_i,
    output logic [DATA_W-1:0] data_o,
    output logic              done_o
);

    // Load the data register and raise done for the cycle after the load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= capture_i;
            if (capture_i) begin
                data_o <= bus_d_i;
            end
        end
    end

endmodule

// File: rtl/periph_read_seq.sv
// Timed peripheral read sequencer, top level.
// Converts nanosecond minimums into rounded-up clock counts and wires the
// phase timer, phase controller, address holder and data capture together.
// Assumes a free-running clock of period CLK_NS and a synchronous reset.
module periph_read_seq
    import rdseq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 11,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned CLK_NS     = 100,
    parameter int unsigned STEP_NS    = 200,
    parameter int unsigned STROBE_NS  = 200,
    parameter int unsigned RECOVER_NS = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    input  logic              ack_i,
    output logic [ADDR_W-1:0] bus_a_o,
    output logic              rd_n_o,
    output logic              ce_n_o,
    input  logic [DATA_W-1:0] bus_d_i
);

    localparam int unsigned STEP_CYC  = max2(1, ceil_div(STEP_NS, CLK_NS));
    localparam int unsigned STRB_CYC  = ceil_div(STROBE_NS, CLK_NS);
    localparam int unsigned LOW_CYC   = max2(STEP_CYC, STRB_CYC);
    localparam int unsigned REC_CYC   = ceil_div(RECOVER_NS, CLK_NS);
    localparam int unsigned REC_EXTRA = (REC_CYC > STEP_CYC) ? (REC_CYC - STEP_CYC) : 0;
    localparam int unsigned CAPT_RAW  = max2(1, ceil_div(STEP_NS, 2 * CLK_NS));
    localparam int unsigned CAPT_CYC  = (CAPT_RAW > STEP_CYC) ? STEP_CYC : CAPT_RAW;
    localparam int unsigned CNT_MAX   = max2(max2(LOW_CYC, STEP_CYC), REC_EXTRA);
    localparam int unsigned CNT_W     = max2(1, $clog2(CNT_MAX + 1));

    logic [CNT_W-1:0] phase_cnt;
    logic             phase_clr;
    logic             load_addr;
    logic             capture;

    rdseq_phase_timer #(
        .CNT_W   (CNT_W),
        .CNT_MAX (CNT_MAX)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (phase_clr),
        .cnt_o (phase_cnt)
    );

    rdseq_ctrl #(
        .CNT_W     (CNT_W),
        .STEP_CYC  (STEP_CYC),
        .LOW_CYC   (LOW_CYC),
        .REC_EXTRA (REC_EXTRA),
        .CAPT_CYC  (CAPT_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .ack_i       (ack_i),
        .cnt_i       (phase_cnt),
        .phase_clr_o (phase_clr),
        .load_addr_o (load_addr),
        .capture_o   (capture),
        .busy_o      (busy_o),
        .rd_n_o      (rd_n_o),
        .ce_n_o      (ce_n_o)
    );

    rdseq_addr_hold #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_addr),
        .addr_i  (addr_i),
        .bus_a_o (bus_a_o)
    );

    rdseq_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .bus_d_i   (bus_d_i),
        .data_o    (data_o),
        .done_o    (done_o)
    );

endmodule

// File: rtl/rdseq_chk.sv
// Protocol checker for the read sequencer, bound to the top level.
// Measures strobe low time and chip-enable high time with saturating counters.
module rdseq_chk
    import rdseq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 11,
    parameter int unsigned CLK_NS     = 100,
    parameter int unsigned STROBE_NS  = 200,
    parameter int unsigned RECOVER_NS = 300
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [ADDR_W-1:0] bus_a_o,
    input logic              rd_n_o,
    input logic              ce_n_o
);

    localparam logic [7:0] STRB_MIN = 8'(ceil_div(STROBE_NS, CLK_NS));
    localparam logic [7:0] REC_MIN  = 8'(ceil_div(RECOVER_NS, CLK_NS));

    logic [7:0] low_cnt;
    logic [7:0] hi_cnt;

    // Count consecutive cycles with the read strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!rd_n_o) begin
            low_cnt <= (low_cnt == 8'hFF) ? low_cnt : low_cnt + 8'd1;
        end else begin
            low_cnt <= '0;
        end
    end

    // Count consecutive cycles with chip-enable high; reset counts as recovered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= REC_MIN;
        end else if (ce_n_o) begin
            hi_cnt <= (hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 8'd1;
        end else begin
            hi_cnt <= '0;
        end
    end

    // R3
    strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n_o == ce_n_o);

    // R3
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_n_o) && $past(rst_n)) |-> (low_cnt >= STRB_MIN));

    // R4
    strobe_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_n_o) && $past(rst_n)) |-> $past(ack_i));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(bus_a_o));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R8
    recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce_n_o) |-> (hi_cnt >= REC_MIN));

endmodule

bind periph_read_seq rdseq_chk #(
    .ADDR_W     (ADDR_W),
    .CLK_NS     (CLK_NS),
    .STROBE_NS  (STROBE_NS),
    .RECOVER_NS (RECOVER_NS)
) u_rdseq_chk (.*);

// File: tb/periph_read_seq_test.sv
// Directed bench for the read sequencer at default parameters (2-cycle step,
// 2-cycle strobe minimum, 3-cycle recovery, capture 1 edge after release).
module periph_read_seq_test;

    localparam int CLK_PERIOD = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [10:0] addr_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [7:0]  data_o;
    logic        ack_i = 1'b0;
    logic [10:0] bus_a_o;
    logic        rd_n_o;
    logic        ce_n_o;
    logic [7:0]  bus_d_i = '0;

    int checks = 0;
    int errors = 0;

    periph_read_seq uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .addr_i  (addr_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .data_o  (data_o),
        .ack_i   (ack_i),
        .bus_a_o (bus_a_o),
        .rd_n_o  (rd_n_o),
        .ce_n_o  (ce_n_o),
        .bus_d_i (bus_d_i)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // R1: outputs in the cycle after a reset edge.
    task automatic check_reset_state();
        @(negedge clk);
        check(rd_n_o == 1'b1, "R1", "rd_n", 32'(rd_n_o), 32'd1);
        check(ce_n_o == 1'b1, "R1", "ce_n", 32'(ce_n_o), 32'd1);
        check(busy_o == 1'b0, "R1", "busy", 32'(busy_o), 32'd0);
        check(done_o == 1'b0, "R1", "done", 32'(done_o), 32'd0);
        check(data_o == 8'h00, "R1", "data", 32'(data_o), 32'd0);
    endtask

    // One access; ack raised in cycle ack_at, optional stray start in cycle stray_k.
    task automatic run_read(input logic [10:0] a, input logic [7:0] d, input int ack_at,
                            input int stray_k, input logic [10:0] a2);
        int j;
        j = (ack_at + 1 > 4) ? ack_at + 1 : 4;
        start_i = 1'b1;
        addr_i  = a;
        @(posedge clk);
        for (int k = 0; k <= j + 3; k++) begin
            @(negedge clk);
            start_i = (k == stray_k);
            if (k == stray_k) addr_i = a2;
            ack_i   = (k >= ack_at);
            bus_d_i = (k <= j) ? d : ~d;
            begin
                logic exp_strb;
                exp_strb = !((k >= 2) && (k < j));
                check(rd_n_o == exp_strb, (k >= 4) ? "R4" : "R3", $sformatf("rd_n cycle %0d", k),
                      32'(rd_n_o), 32'(exp_strb));
                check(ce_n_o == exp_strb, "R3", $sformatf("ce_n cycle %0d", k),
                      32'(ce_n_o), 32'(exp_strb));
                check(busy_o == (k <= j + 2), "R8", $sformatf("busy cycle %0d", k),
                      32'(busy_o), 32'(k <= j + 2));
                check(done_o == (k == j + 1), "R6", $sformatf("done cycle %0d", k),
                      32'(done_o), 32'(k == j + 1));
                check(bus_a_o == a, (k == 0) ? "R2" : "R5", $sformatf("addr cycle %0d", k),
                      32'(bus_a_o), 32'(a));
                if (k >= j + 1)
                    check(data_o == d, "R6", $sformatf("data cycle %0d", k),
                          32'(data_o), 32'(d));
            end
        end
        start_i = 1'b0;
        ack_i   = 1'b0;
    endtask

    // R9: no second access after a start seen while busy.
    task automatic check_no_restart(input logic [10:0] a);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(busy_o == 1'b0, "R9", "busy after stray start", 32'(busy_o), 32'd0);
            check(rd_n_o == 1'b1, "R9", "rd_n after stray start", 32'(rd_n_o), 32'd1);
            check(bus_a_o == a, "R9", "addr after stray start", 32'(bus_a_o), 32'(a));
        end
    endtask

    // R7: captured byte survives bus activity.
    task automatic check_retention(input logic [7:0] d);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            bus_d_i = d ^ 8'(k + 1);
            check(data_o == d, "R7", "data retained", 32'(data_o), 32'(d));
            check(done_o == 1'b0, "R7", "no done", 32'(done_o), 32'd0);
        end
    endtask

    // R1: reset while the strobes are low.
    task automatic reset_mid_access();
        start_i = 1'b1;
        addr_i  = 11'h123;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(rd_n_o == 1'b0, "R3", "strobe low before reset", 32'(rd_n_o), 32'd0);
        rst_n = 1'b0;
        @(posedge clk);
        check_reset_state();
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        check_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        run_read(11'h011, 8'h5A, 0, -1, 11'h000);
        check_no_restart(11'h011);
        run_read(11'h7FF, 8'hA5, 7, -1, 11'h000);
        run_read(11'h003, 8'h3C, 0, 3, 11'h155);
        check_no_restart(11'h003);
        run_read(11'h400, 8'hC3, 2, 6, 11'h2AA);
        check_no_restart(11'h400);
        run_read(11'h0F0, 8'h0F, 0, -1, 11'h000);
        run_read(11'h70F, 8'hF0, 5, -1, 11'h000);
        check_retention(8'hF0);
        reset_mid_access();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule